// File: doc/BRIEF.md
# Companion GPIO and Card Register Block

This block is a small memory-mapped register file that sits beside a host processor. It holds a mode word, a card-detect word, a fixed card-status word, a card-power word, a card-control word and three interrupt words (routing, mask and status). These words are plain storage. The block does not act on their meaning.

It also holds a 16-line general-purpose port with a direction register and a level register. The port drives `gpioOut`, which is the level register gated by the direction register. For each line, `gpioChg` gives a one-cycle pulse when that line's driven value changes.

The external `pinIn` lines are sampled every cycle. When a sampled pin toggles, the matching level bit follows it, whatever the direction setting.

Bus reads are combinational from `busAddr`. Bus writes take effect on the clock edge on which `busWrEn` is high.

Top module: `cmpn_gpio_regs`

## Requirements
- R1: After reset, the card-status word (byte offset 0x08) reads 0x0002. Every other register reads 0x0000, and `gpioOut` and `gpioChg` are 0.
- R2: A write to the mode (0x00), card-detect (0x04), card-control (0x10), routing (0x14), mask (0x18), interrupt-status (0x1C) or direction (0x20) offset stores `busWrData[15:0]`. The upper bits are dropped, and a read of the same offset returns the stored word.
- R3: A write to the power offset (0x0C) stores `busWrData[15:0]`. When bit 7 of the written data is 1, bits 15 and 6 are also set, so the stored word is `data | 0x8040`.
- R4: The card-status offset 0x08 is read-only: a write there is ignored and reads keep returning 0x0002.
- R5: A write to either level offset (0x24 or 0x28) stores `busWrData[15:0] & direction`. A read of either offset returns the level register.
- R6: `gpioOut` equals `level & direction` at all times.
- R7: When bit i of `gpioOut` changes on a clock edge, `gpioChg[i]` is 1 for exactly the following cycle and is 0 otherwise.
- R8: A toggle on `pinIn[i]` is sampled on the next edge. On the edge after that, level bit i takes the pin's value, whether line i is set as an input or an output.
- R9: If a pin toggle would update the level register in the same cycle as a bus write to a level offset, the bus write is stored first. The pin update is applied on the following edge.
- R10: Any offset not listed above (including misaligned ones) reads as 0x0000, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte offset of the access |
| busWrEn | input | 1 | Write strobe for the current cycle |
| busWrData | input | 32 | Write data; only bits 15:0 are kept |
| busRdData | output | 16 | Read data for `busAddr`, combinational |
| pinIn | input | 16 | External input lines |
| gpioOut | output | 16 | Driven port value, level AND direction |
| gpioChg | output | 16 | One-cycle change pulse per line |

## Verification
The assertions assume that there is at most one bus access per cycle. They also assume that `busWrData` and `busAddr` are stable around the clock edge and that the pins do not toggle during cycles on which the level-write check is meant to hold.

The stimulus keeps `pinIn` constant throughout the random bus phase. As a result, the level register there changes only through bus writes, and the pin-driven paths are covered by directed sequences with known pin histories. The random phase draws offsets from all mapped words plus several unmapped and misaligned ones, and uses full 32-bit data so that truncation is exercised.

// File: rtl/cmpn_pkg.sv
package cmpn_pkg;
  localparam int RegW = 16;
  localparam logic [RegW-1:0] StatusInit = 16'h0002;
  localparam logic [RegW-1:0] PowerForce = 16'h8040;
  localparam int PowerTrigBit = 7;

  localparam logic [7:0] OffMode   = 8'h00;
  localparam logic [7:0] OffCdet   = 8'h04;
  localparam logic [7:0] OffStat   = 8'h08;
  localparam logic [7:0] OffPower  = 8'h0C;
  localparam logic [7:0] OffCctl   = 8'h10;
  localparam logic [7:0] OffRoute  = 8'h14;
  localparam logic [7:0] OffMask   = 8'h18;
  localparam logic [7:0] OffIstat  = 8'h1C;
  localparam logic [7:0] OffDir    = 8'h20;
  localparam logic [7:0] OffLevelW = 8'h24;
  localparam logic [7:0] OffLevelR = 8'h28;

  typedef enum logic [3:0] {
    SelNone, SelMode, SelCdet, SelStat, SelPower, SelCctl,
    SelRoute, SelMask, SelIstat, SelDir, SelLevel
  } rdSel_e;

  typedef struct packed {
    logic   wrMode;
    logic   wrCdet;
    logic   wrPower;
    logic   wrCctl;
    logic   wrRoute;
    logic   wrMask;
    logic   wrIstat;
    logic   wrDir;
    logic   wrLevel;
    rdSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/cmpn_ctrl.sv
module cmpn_ctrl
  import cmpn_pkg::*;
#(
  parameter int AddrW = 8
) (
  input  logic [AddrW-1:0] busAddr,
  input  logic             busWrEn,
  output ctrlStrobe_t      ctl
);
  localparam int PadW = (AddrW > 8) ? AddrW - 8 : 0;

  logic [AddrW-1:0] offs [0:10];

  always_comb begin
    offs[0]  = AddrW'(OffMode);
    offs[1]  = AddrW'(OffCdet);
    offs[2]  = AddrW'(OffStat);
    offs[3]  = AddrW'(OffPower);
    offs[4]  = AddrW'(OffCctl);
    offs[5]  = AddrW'(OffRoute);
    offs[6]  = AddrW'(OffMask);
    offs[7]  = AddrW'(OffIstat);
    offs[8]  = AddrW'(OffDir);
    offs[9]  = AddrW'(OffLevelW);
    offs[10] = AddrW'(OffLevelR);
  end

  always_comb begin
    ctl = '0;
    ctl.rdSel = SelNone;
    if (busAddr == offs[0]) begin
      ctl.rdSel = SelMode;   ctl.wrMode = busWrEn;
    end else if (busAddr == offs[1]) begin
      ctl.rdSel = SelCdet;   ctl.wrCdet = busWrEn;
    end else if (busAddr == offs[2]) begin
      ctl.rdSel = SelStat;
    end else if (busAddr == offs[3]) begin
      ctl.rdSel = SelPower;  ctl.wrPower = busWrEn;
    end else if (busAddr == offs[4]) begin
      ctl.rdSel = SelCctl;   ctl.wrCctl = busWrEn;
    end else if (busAddr == offs[5]) begin
      ctl.rdSel = SelRoute;  ctl.wrRoute = busWrEn;
    end else if (busAddr == offs[6]) begin
      ctl.rdSel = SelMask;   ctl.wrMask = busWrEn;
    end else if (busAddr == offs[7]) begin
      ctl.rdSel = SelIstat;  ctl.wrIstat = busWrEn;
    end else if (busAddr == offs[8]) begin
      ctl.rdSel = SelDir;    ctl.wrDir = busWrEn;
    end else if (busAddr == offs[9] || busAddr == offs[10]) begin
      ctl.rdSel = SelLevel;  ctl.wrLevel = busWrEn;
    end
  end

  if (PadW > 0) begin : g_wide_note
    // Wider address buses decode the full offset; upper bits must be zero.
  end
endmodule

// File: rtl/cmpn_datapath.sv
module cmpn_datapath
  import cmpn_pkg::*;
#(
  parameter int DataW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      ctl,
  input  logic [DataW-1:0] busWrData,
  input  logic [RegW-1:0]  pinIn,
  output logic [RegW-1:0]  busRdData,
  output logic [RegW-1:0]  gpioOut,
  output logic [RegW-1:0]  gpioChg
);
  logic [RegW-1:0] wData;
  logic [RegW-1:0] modeReg, cdetReg, powerReg, cctlReg;
  logic [RegW-1:0] routeReg, maskReg, istatReg, dirReg, levelReg;
  logic [RegW-1:0] pinSamp, pinPrev, pinDiff, levelNext;
  logic [RegW-1:0] effNow, effPrev, chgReg;

  assign wData = busWrData[RegW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg  <= '0;
      cdetReg  <= '0;
      powerReg <= '0;
      cctlReg  <= '0;
      routeReg <= '0;
      maskReg  <= '0;
      istatReg <= '0;
      dirReg   <= '0;
    end else begin
      if (ctl.wrMode)  modeReg  <= wData;
      if (ctl.wrCdet)  cdetReg  <= wData;
      if (ctl.wrPower) powerReg <= wData[PowerTrigBit] ? (wData | PowerForce) : wData;
      if (ctl.wrCctl)  cctlReg  <= wData;
      if (ctl.wrRoute) routeReg <= wData;
      if (ctl.wrMask)  maskReg  <= wData;
      if (ctl.wrIstat) istatReg <= wData;
      if (ctl.wrDir)   dirReg   <= wData;
    end
  end

  // Pin toggles follow into the level register unless a bus level write
  // owns this cycle; then the toggle stays pending for one more edge.
  assign pinDiff = pinSamp ^ pinPrev;

  for (genvar i = 0; i < RegW; i++) begin : g_line
    assign levelNext[i] = ctl.wrLevel ? (wData[i] & dirReg[i])
                        : (pinDiff[i] ? pinSamp[i] : levelReg[i]);
    assign effNow[i]    = levelReg[i] & dirReg[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelReg <= '0;
      pinSamp  <= '0;
      pinPrev  <= '0;
      effPrev  <= '0;
      chgReg   <= '0;
    end else begin
      levelReg <= levelNext;
      pinSamp  <= pinIn;
      if (!ctl.wrLevel) pinPrev <= pinSamp;
      effPrev  <= effNow;
      chgReg   <= effNow ^ effPrev;
    end
  end

  assign gpioOut = effNow;
  assign gpioChg = chgReg;

  always_comb begin
    unique case (ctl.rdSel)
      SelMode:  busRdData = modeReg;
      SelCdet:  busRdData = cdetReg;
      SelStat:  busRdData = StatusInit;
      SelPower: busRdData = powerReg;
      SelCctl:  busRdData = cctlReg;
      SelRoute: busRdData = routeReg;
      SelMask:  busRdData = maskReg;
      SelIstat: busRdData = istatReg;
      SelDir:   busRdData = dirReg;
      SelLevel: busRdData = levelReg;
      default:  busRdData = '0;
    endcase
  end
endmodule

// File: rtl/cmpn_gpio_regs.sv
module cmpn_gpio_regs
  import cmpn_pkg::*;
#(
  parameter int AddrW = 8,
  parameter int DataW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] busAddr,
  input  logic             busWrEn,
  input  logic [DataW-1:0] busWrData,
  output logic [RegW-1:0]  busRdData,
  input  logic [RegW-1:0]  pinIn,
  output logic [RegW-1:0]  gpioOut,
  output logic [RegW-1:0]  gpioChg
);
  ctrlStrobe_t ctl;

  cmpn_ctrl #(.AddrW(AddrW)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .ctl     (ctl)
  );

  cmpn_datapath #(.DataW(DataW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .busWrData (busWrData),
    .pinIn     (pinIn),
    .busRdData (busRdData),
    .gpioOut   (gpioOut),
    .gpioChg   (gpioChg)
  );
endmodule

// File: rtl/cmpn_gpio_regs_chk.sv
module cmpn_gpio_regs_chk #(
  parameter int AddrW = 8,
  parameter int DataW = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [AddrW-1:0] busAddr,
  input logic             busWrEn,
  input logic [DataW-1:0] busWrData,
  input logic [15:0]      busRdData,
  input logic [15:0]      gpioOut,
  input logic [15:0]      gpioChg,
  input logic [15:0]      dirReg,
  input logic [15:0]      powerReg
);
  logic wrPow, wrDir, wrLvl, unmapped;
  assign wrPow = busWrEn && busAddr == AddrW'(8'h0C);
  assign wrDir = busWrEn && busAddr == AddrW'(8'h20);
  assign wrLvl = busWrEn && (busAddr == AddrW'(8'h24) || busAddr == AddrW'(8'h28));
  assign unmapped = (busAddr[1:0] != 2'b00) || (busAddr > AddrW'(8'h28));

  assert_dir_store_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrDir |=> dirReg == $past(busWrData[15:0]));

  assert_power_force_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrPow && busWrData[7] |=> powerReg == ($past(busWrData[15:0]) | 16'h8040));

  assert_power_plain_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrPow && !busWrData[7] |=> powerReg == $past(busWrData[15:0]));

  assert_status_fixed_R4: assert property (@(posedge clk) disable iff (!rstN)
    busAddr == AddrW'(8'h08) |-> busRdData == 16'h0002);

  assert_level_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrLvl |=> gpioOut == ($past(busWrData[15:0]) & $past(dirReg)));

  assert_change_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    gpioChg == ($past(gpioOut) ^ $past(gpioOut, 2)));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    unmapped |-> busRdData == 16'h0000);
endmodule

bind cmpn_gpio_regs cmpn_gpio_regs_chk #(.AddrW(AddrW), .DataW(DataW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .gpioOut   (gpioOut),
  .gpioChg   (gpioChg),
  .dirReg    (u_dp.dirReg),
  .powerReg  (u_dp.powerReg)
);

// File: tb/cmpn_gpio_regs_bench.sv
`timescale 1ns/1ps
module cmpn_gpio_regs_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = 8'hFC;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [15:0] pinIn = '0;
  logic [15:0] gpioOut;
  logic [15:0] gpioChg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] mReg [0:10];
  logic [15:0] mPins = '0;

  always #2 clk = ~clk;

  cmpn_gpio_regs u_cmpn_gpio_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .gpioOut(gpioOut), .gpioChg(gpioChg)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] modelStore(input int idx, input logic [31:0] d,
                                             input logic [15:0] old);
    logic [15:0] w = d[15:0];
    case (idx)
      2:       return old;
      3:       return w[7] ? (w | 16'h8040) : w;
      9, 10:   return w & mReg[8];
      default: return w;
    endcase
  endfunction

  function automatic logic [15:0] modelRead(input int idx);
    if (idx == 10) return mReg[9];
    if (idx < 0 || idx > 10) return 16'h0000;
    return mReg[idx];
  endfunction

  function automatic logic [15:0] modelEff();
    return mReg[9] & mReg[8];
  endfunction

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    @(negedge clk);
    busAddr = a;
    busWrEn = 1'b0;
    #1 v = busRdData;
  endtask

  task automatic doWr(input logic [7:0] a, input logic [31:0] d);
    int idx;
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 8'hFC;
    idx = (a[1:0] == 2'b00 && a <= 8'h28) ? int'(a >> 2) : -1;
    if (idx == 10) mReg[9] = modelStore(10, d, mReg[9]);
    else if (idx >= 0) mReg[idx] = modelStore(idx, d, mReg[idx]);
  endtask

  task automatic setPins(input logic [15:0] p);
    logic [15:0] chg;
    @(negedge clk);
    pinIn = p;
    chg = p ^ mPins;
    mReg[9] = (mReg[9] & ~chg) | (p & chg);
    mPins = p;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    logic [15:0] oldEff;
    void'($urandom(32'd1234));
    for (int i = 0; i <= 10; i++) mReg[i] = '0;
    mReg[2] = 16'h0002;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int i = 0; i <= 10; i++) begin
      rd(8'(i * 4), v);
      check("R1 reset value", v, modelRead(i));
    end
    check("R1 gpioOut reset", gpioOut, 16'h0);
    check("R1 gpioChg reset", gpioChg, 16'h0);

    // R2 truncation
    doWr(8'h00, 32'hABCD_1234);
    rd(8'h00, v); check("R2 mode truncated", v, 16'h1234);
    doWr(8'h1C, 32'hFFFF_8001);
    rd(8'h1C, v); check("R2 istat truncated", v, 16'h8001);

    // R3 power rule
    doWr(8'h0C, 32'h0001_0080);
    rd(8'h0C, v); check("R3 power forced bits", v, 16'h80C0);
    doWr(8'h0C, 32'h0000_0041);
    rd(8'h0C, v); check("R3 power plain", v, 16'h0041);

    // R4 status read-only
    doWr(8'h08, 32'h0000_FFFF);
    rd(8'h08, v); check("R4 status ignores write", v, 16'h0002);

    // R10 unmapped
    doWr(8'h2C, 32'h0000_FFFF);
    doWr(8'h06, 32'h0000_FFFF);
    rd(8'h2C, v); check("R10 unmapped read", v, 16'h0);
    rd(8'h06, v); check("R10 misaligned read", v, 16'h0);
    for (int i = 0; i <= 10; i++) begin
      rd(8'(i * 4), v);
      check("R10 state unchanged", v, modelRead(i));
    end

    // R5/R6/R7 level, alias, strobe
    doWr(8'h20, 32'h0000_00FF);
    doWr(8'h28, 32'h0000_0F05);
    rd(8'h24, v); check("R5 level masked by dir via alias", v, 16'h0005);
    check("R6 gpioOut", gpioOut, 16'h0005);
    oldEff = modelEff();
    doWr(8'h20, 32'h0000_0001);
    check("R6 gpioOut after dir", gpioOut, 16'h0001);
    @(negedge clk); check("R7 strobe on dir change", gpioChg, oldEff ^ modelEff());
    @(negedge clk); check("R7 strobe one cycle", gpioChg, 16'h0);

    // R8 pins update level regardless of direction
    doWr(8'h20, 32'h0);
    setPins(16'hA5A5);
    rd(8'h28, v); check("R8 pins set level", v, mReg[9]);
    check("R8 output gated", gpioOut, 16'h0);
    setPins(16'h0000);
    rd(8'h24, v); check("R8 pins clear level", v, mReg[9]);

    // R9 bus write beats same-cycle pin update
    doWr(8'h20, 32'h0000_FFFF);
    @(negedge clk); pinIn = 16'h0F0F;
    @(negedge clk); busAddr = 8'h24; busWrData = 32'h0000_00F0; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0; busAddr = 8'h28;
    #1 check("R9 bus write first", busRdData, 16'h00F0);
    @(negedge clk); #1 check("R9 pin applied next edge", busRdData, 16'h0FFF);
    mReg[9] = 16'h0FFF; mPins = 16'h0F0F;
    setPins(16'h0000);
    repeat (3) @(negedge clk);

    // random phase, pins held constant
    for (int n = 0; n < 400; n++) begin
      int r;
      logic [7:0] a;
      logic [31:0] d;
      r = int'($urandom % 14);
      a = (r <= 10) ? 8'(r * 4) : (r == 11) ? 8'h2C : (r == 12) ? 8'h05 : 8'h80;
      d = $urandom;
      oldEff = modelEff();
      doWr(a, d);
      check("R6 random gpioOut", gpioOut, modelEff());
      @(negedge clk); check("R7 random strobe", gpioChg, oldEff ^ modelEff());
      r = int'($urandom % 12);
      rd(8'(r * 4), v);
      check("R2 R5 random readback", v, modelRead(r));
      check("R7 random strobe cleared", gpioChg, 16'h0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule